// File: doc/BRIEF.md
# Port Retrain Request Controller

This block sits on the register side of one switch port. It watches a simple register write bus and turns software writes into one-cycle commands for the port's link training state machine. A partial retrain command sends that state machine straight to Recovery. A full retrain command sends it straight to Detect. Whether a partial retrain is honoured depends on a strap that marks the port as upstream or downstream, and on a global unlock bit taken from the switch control register.

The block also guards the port's maximum link width field. On the upstream port, software may write this field only while the unlock bit is set. On a downstream port the field is fixed. An accepted value is held in a staging register and does not reach the training logic straight away. It is moved into the applied width when the port next trains: either when this block issues a Detect command, or when the training logic raises its training-start input. Retraining of either kind never restores the stored width to its reset value.

Top module: `retrain_req_ctl`

## Requirements
- R1: After reset, `gotoRecovery` and `gotoDetect` are 0 and `maxWidthApplied` equals `DEFAULT_WIDTH` (4).
- R2: On an upstream port (`isUpstream`=1), a write to the control register (address 0) with bit 0 set and bit 1 clear makes `gotoRecovery` 1 in the cycle after the write, and only if `unlock` is 1. If `unlock` is 0, no command is issued.
- R3: On a downstream port (`isUpstream`=0), the same write makes `gotoRecovery` 1 in the cycle after the write, whatever the value of `unlock`.
- R4: A write to the control register with bit 1 set makes `gotoDetect` 1 in the cycle after the write, on either port type and whatever the value of `unlock`.
- R5: If bits 0 and 1 are both set in one control write, only `gotoDetect` is raised. `gotoRecovery` and `gotoDetect` are never 1 together.
- R6: A write to the width register (address 1, bits [5:0]) is staged only on an upstream port with `unlock`=1. Such a write on a locked upstream port, or on any downstream port, leaves the width that later gets applied unchanged.
- R7: A staged width does not appear on `maxWidthApplied` until it is applied. It appears in the same cycle that `gotoDetect` is 1, or in the cycle after `trainStart` is sampled high.
- R8: A partial retrain leaves `maxWidthApplied` unchanged. A full retrain applies the staged value and never the reset default.
- R9: The retrain bits clear themselves. A single control write gives exactly one pulse, which drops in the next cycle without any further write. Writes to other addresses, and control writes with both bits clear, give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (4) | Register write address |
| wrData | input | DATA_W (16) | Register write data |
| unlock | input | 1 | Global register unlock bit |
| isUpstream | input | 1 | Port type strap: 1 = upstream, 0 = downstream |
| trainStart | input | 1 | Training-start indication from the training logic |
| gotoRecovery | output | 1 | One-cycle command: enter Recovery |
| gotoDetect | output | 1 | One-cycle command: enter Detect |
| maxWidthApplied | output | WIDTH_W (6) | Maximum link width used for training |

## Verification
The acceptance logic is driven through all sixteen combinations of port type, unlock bit and the two retrain bits. These combinations separate a lock that wrongly applies to downstream ports, a lock that is missing on the upstream port, and a wrong priority when both bits are set. Each combination is also checked one cycle later, which catches a pulse that does not clear. Width sequences then stage a value and trigger a partial retrain, a full retrain and a training-start pulse. They show whether the width is applied too early, applied by the wrong event, restored to its default, or accepted while locked or on a downstream port.

// File: rtl/retrain_pkg.sv
package retrain_pkg;
  // Strobes from the control module to the width datapath.
  typedef struct packed {
    logic fireRecovery;
    logic fireDetect;
    logic stageWidth;
    logic applyWidth;
  } ctlStrobes_t;
endpackage

// File: rtl/retrain_ctl.sv
module retrain_ctl
  import retrain_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int CTL_ADDR = 0,
  parameter int WID_ADDR = 1,
  parameter int LINK_BIT = 0,
  parameter int FULL_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              unlock,
  input  logic              isUpstream,
  input  logic              trainStart,
  output ctlStrobes_t       stb,
  output logic              recPulse,
  output logic              detPulse
);
  localparam logic [ADDR_W-1:0] CtlSel = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] WidSel = ADDR_W'(WID_ADDR);

  logic ctlHit, widHit, linkReq, fullReq, linkAllowed;

  always_comb begin
    ctlHit      = wrEn && (wrAddr == CtlSel);
    widHit      = wrEn && (wrAddr == WidSel);
    fullReq     = ctlHit && wrData[FULL_BIT];
    // A full retrain outranks a partial retrain.
    linkAllowed = !isUpstream || unlock;
    linkReq     = ctlHit && wrData[LINK_BIT] && linkAllowed && !fullReq;
    stb.fireRecovery = linkReq;
    stb.fireDetect   = fullReq;
    stb.stageWidth   = widHit && isUpstream && unlock;
    stb.applyWidth   = fullReq || trainStart;
  end

  // Retrain bits clear themselves: each accepted write gives one pulse.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      recPulse <= 1'b0;
      detPulse <= 1'b0;
    end else begin
      recPulse <= stb.fireRecovery;
      detPulse <= stb.fireDetect;
    end
  end

  assert_locked_up_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlHit && isUpstream && !unlock && !wrData[FULL_BIT]) |=> (!recPulse && !detPulse));

  assert_down_retrain_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlHit && !isUpstream && wrData[LINK_BIT] && !wrData[FULL_BIT]) |=> recPulse);

  assert_full_retrain_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlHit && wrData[FULL_BIT]) |=> (detPulse && !recPulse));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(recPulse && detPulse));

  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    (recPulse || detPulse) |-> $past(ctlHit));
endmodule

// File: rtl/retrain_width_dp.sv
module retrain_width_dp
  import retrain_pkg::*;
#(
  parameter int WIDTH_W       = 6,
  parameter int DEFAULT_WIDTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        stb,
  input  logic [WIDTH_W-1:0] wrWidth,
  output logic [WIDTH_W-1:0] appliedWidth
);
  localparam logic [WIDTH_W-1:0] ResetWidth = WIDTH_W'(DEFAULT_WIDTH);

  logic [WIDTH_W-1:0] stagedWidth;

  // Only reset restores the default. Retraining only copies staged to applied.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedWidth  <= ResetWidth;
      appliedWidth <= ResetWidth;
    end else begin
      if (stb.stageWidth) stagedWidth <= wrWidth;
      if (stb.applyWidth) appliedWidth <= stagedWidth;
    end
  end

  assert_apply_staged_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.applyWidth |=> (appliedWidth == $past(stagedWidth)));

  assert_recovery_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fireRecovery && !stb.applyWidth) |=> $stable(appliedWidth));
endmodule

// File: rtl/retrain_req_ctl.sv
module retrain_req_ctl
  import retrain_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 16,
  parameter int WIDTH_W       = 6,
  parameter int DEFAULT_WIDTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               unlock,
  input  logic               isUpstream,
  input  logic               trainStart,
  output logic               gotoRecovery,
  output logic               gotoDetect,
  output logic [WIDTH_W-1:0] maxWidthApplied
);
  ctlStrobes_t stb;
  logic        unusedBits;

  assign unusedBits = ^wrData[DATA_W-1:WIDTH_W];

  retrain_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTL_ADDR(0), .WID_ADDR(1), .LINK_BIT(0), .FULL_BIT(1)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .unlock(unlock), .isUpstream(isUpstream), .trainStart(trainStart),
    .stb(stb), .recPulse(gotoRecovery), .detPulse(gotoDetect)
  );

  retrain_width_dp #(
    .WIDTH_W(WIDTH_W), .DEFAULT_WIDTH(DEFAULT_WIDTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrWidth(wrData[WIDTH_W-1:0]), .appliedWidth(maxWidthApplied)
  );
endmodule

// File: tb/retrain_req_ctl_bench.sv
module retrain_req_ctl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        unlock = 1'b0;
  logic        isUpstream = 1'b0;
  logic        trainStart = 1'b0;
  logic        gotoRecovery, gotoDetect;
  logic [5:0]  maxWidthApplied;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  retrain_req_ctl u_retrain_req_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .unlock(unlock), .isUpstream(isUpstream), .trainStart(trainStart),
    .gotoRecovery(gotoRecovery), .gotoDetect(gotoDetect),
    .maxWidthApplied(maxWidthApplied)
  );

  // Vector fields: {isUpstream, unlock, fullBit, linkBit, expRecovery, expDetect}
  localparam logic [5:0] VEC [16] = '{
    6'b0000_00, 6'b0001_10, 6'b0010_01, 6'b0011_01,
    6'b0100_00, 6'b0101_10, 6'b0110_01, 6'b0111_01,
    6'b1000_00, 6'b1001_00, 6'b1010_01, 6'b1011_01,
    6'b1100_00, 6'b1101_10, 6'b1110_01, 6'b1111_01
  };

  task automatic check(input int actual, input int expected, input string tag);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Write drives at the falling edge. Outputs are sampled 1 ns after the capturing edge.
  task automatic writeReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idleCycle();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(gotoRecovery, 0, "R1 recovery during reset");
    check(gotoDetect, 0, "R1 detect during reset");
    @(negedge clk); rstN = 1'b1;
    idleCycle();
    check(gotoRecovery, 0, "R1 recovery after reset");
    check(gotoDetect, 0, "R1 detect after reset");
    check(maxWidthApplied, 4, "R1 default width");

    // Acceptance table
    for (int i = 0; i < 16; i++) begin
      string tag;
      logic [5:0] v;
      v = VEC[i];
      if (v[3]) tag = v[2] ? "R5" : "R4";
      else      tag = v[5] ? "R2" : "R3";
      @(negedge clk);
      isUpstream = v[5]; unlock = v[4];
      writeReg(4'd0, {14'd0, v[3], v[2]});
      check(gotoRecovery, v[1], $sformatf("%s vec%0d recovery", tag, i));
      check(gotoDetect, v[0], $sformatf("%s vec%0d detect", tag, i));
      check(gotoRecovery && gotoDetect, 0, "R5 exclusive");
      idleCycle();
      check(gotoRecovery, 0, $sformatf("R9 vec%0d recovery cleared", i));
      check(gotoDetect, 0, $sformatf("R9 vec%0d detect cleared", i));
    end

    // Ignored writes
    @(negedge clk); isUpstream = 1'b0; unlock = 1'b1;
    writeReg(4'd3, 16'h0003);
    check(gotoRecovery | gotoDetect, 0, "R9 other address no pulse");
    writeReg(4'd0, 16'hFFFC);
    check(gotoRecovery | gotoDetect, 0, "R9 zero retrain bits no pulse");
    check(maxWidthApplied, 4, "R8 width unchanged by vectors");

    // Staging, then partial retrain, then full retrain
    @(negedge clk); isUpstream = 1'b1; unlock = 1'b1;
    writeReg(4'd1, 16'd2);
    check(maxWidthApplied, 4, "R7 staged not yet applied");
    writeReg(4'd0, 16'h0001);
    check(gotoRecovery, 1, "R2 unlocked upstream recovery");
    check(maxWidthApplied, 4, "R8 recovery keeps width");
    writeReg(4'd0, 16'h0002);
    check(gotoDetect, 1, "R4 detect pulse");
    check(maxWidthApplied, 2, "R7 applied with detect");

    // Locked upstream write
    @(negedge clk); unlock = 1'b0;
    writeReg(4'd1, 16'd3);
    writeReg(4'd0, 16'h0002);
    check(maxWidthApplied, 2, "R6 locked upstream ignored");

    // Downstream write
    @(negedge clk); isUpstream = 1'b0; unlock = 1'b1;
    writeReg(4'd1, 16'd5);
    writeReg(4'd0, 16'h0002);
    check(maxWidthApplied, 2, "R6 downstream ignored");
    check(maxWidthApplied == 4, 0, "R8 no revert to default");

    // Training start applies
    @(negedge clk); isUpstream = 1'b1; unlock = 1'b1;
    writeReg(4'd1, 16'd6);
    idleCycle();
    check(maxWidthApplied, 2, "R7 held before trainStart");
    @(negedge clk); trainStart = 1'b1;
    @(posedge clk); #1; trainStart = 1'b0;
    check(maxWidthApplied, 6, "R7 applied by trainStart");
    check(gotoDetect | gotoRecovery, 0, "R9 trainStart no pulse");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule